// File: doc/BRIEF.md
# Precise Trap Controller

This block is the control unit that turns faults and external interrupts into precise traps for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at the fault flags and cause codes that the four flushable stages present, at an external interrupt request with its source number, and at a return-from-trap signal that is asserted when that instruction reaches writeback. When a trap is taken, the instruction that takes it and every younger instruction are turned into bubbles. Older instructions go on to complete. Fetch is redirected to a handler address read from an eight-entry vector table. The trapping PC and a cause code are stored so that the handler can return.

The control is a three-state machine. In RUN, traps are accepted: the TAKE transition goes to HANDLER, and a return in RUN redirects but stays in RUN. In HANDLER, further traps are masked. The first one that arrives is parked by the PARK transition into HELD. A return with nothing parked takes the RETURN transition back to RUN. A return that meets a parked trap, or that coincides with an interrupt, takes the CHAIN transition: the controller goes straight into that trap and ends in HANDLER. Software programs the vector table through a write port. After reset, every entry holds a default handler address.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, flush_o is 0, redirect_o is 0, epc_o is 0, cause_o is 0, and every vector entry holds DEFAULT_VEC (0x0000_0100).
- R2: In RUN, a fault flagged at stage k (flush_o and exc_valid_i bit 0 = fetch, 1 = decode, 2 = execute, 3 = memory) raises redirect_o in the same cycle. It sets flush_o bits k down to 0, leaves older bits clear, and drives redirect_pc_o with the vector entry indexed by the cause.
- R3: When several stages flag faults in one cycle, the oldest one wins. The memory stage is oldest and fetch is youngest. The winner's cause code is the one taken from exc_cause_i (bits 2k+1:2k for stage k), even if that code differs from the code the stage would raise itself.
- R4: One cycle after a taken trap, epc_o holds the PC of the trapping stage (stage_pc_i bits 32k+31:32k). cause_o holds {1'b0, code}, where the code is 0 for a fetch address fault, 1 for an illegal opcode, 2 for a divide by zero and 3 for a data address fault. epc_o and cause_o change only when a trap is taken.
- R5: In RUN, with no fault flagged, irq_i takes a trap. flush_o is 4'b1111 and the vector index is {1'b1, irq_src_i}. On the next cycle cause_o equals that index and epc_o equals the memory-stage PC.
- R6: A fault and an interrupt in the same cycle resolve to the fault.
- R7: In HANDLER and HELD, a fault or interrupt without mret_i produces no redirect and no flush, and leaves epc_o and cause_o unchanged.
- R8: mret_i in HANDLER with nothing parked and no interrupt drives redirect_pc_o to epc_o and flush_o to 4'b1111, then returns to RUN, where the next interrupt is taken.
- R9: The first trap that arrives while masked is parked, and later arrivals are dropped. On mret_i the parked trap is taken in place of the return. An interrupt present in the same cycle as mret_i in HANDLER is taken the same way. For a parked fault, epc_o becomes the faulting PC. For an interrupt, epc_o keeps the return address. cause_o takes the parked index.
- R10: Eight 32-bit vector entries, indexed by the cause value, are written through cfg_we_i, cfg_idx_i and cfg_data_i. A write is used by every trap from the next cycle on.
- R11: mret_i outranks any fault flagged in the same cycle, because those instructions are younger. In RUN it redirects to epc_o with flush_o at 4'b1111, leaves epc_o and cause_o unchanged, and stays in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid_i | input | 4 | Per-stage fault flag, bit 0 fetch to bit 3 memory |
| exc_cause_i | input | 8 | Per-stage 2-bit fault code, stage k at bits 2k+1:2k |
| stage_pc_i | input | 128 | Per-stage PC, stage k at bits 32k+31:32k |
| irq_i | input | 1 | External interrupt request (level) |
| irq_src_i | input | 2 | Interrupt source number |
| mret_i | input | 1 | Return-from-trap at writeback |
| cfg_we_i | input | 1 | Vector table write enable |
| cfg_idx_i | input | 3 | Vector table write index |
| cfg_data_i | input | 32 | Vector table write data |
| flush_o | output | 4 | Per-stage bubble request, bit 0 fetch to bit 3 memory |
| redirect_o | output | 1 | Fetch redirect this cycle |
| redirect_pc_o | output | 32 | Redirect target |
| epc_o | output | 32 | Saved trap PC |
| cause_o | output | 3 | Trap cause: bit 2 = interrupt, bits 1:0 = code or source |

## Verification
Trap selection is tried with a single fault in each of the four stages, which shows the flush mask growing stage by stage. Mixed fault patterns show that the oldest stage wins and that its cause is read from its own slot and not from the stage number. Fault-plus-interrupt and interrupt-only cases separate the priority of faults from the interrupt path and its memory-stage PC. Directed sequences then drive traps while masked, a return with parked faults and parked interrupts, an interrupt that arrives together with a return, a return in RUN alongside faults, and vector writes, so that the park, chain and return transitions each show a distinct redirect target and saved PC.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_HANDLER = 2'd1,
        ST_HELD    = 2'd2
    } trap_state_e;

    localparam logic [1:0] CODE_FETCH_FAULT = 2'd0;
    localparam logic [1:0] CODE_ILLEGAL_OP  = 2'd1;
    localparam logic [1:0] CODE_DIV_ZERO    = 2'd2;
    localparam logic [1:0] CODE_DATA_FAULT  = 2'd3;

endpackage

// File: rtl/trap_vec_table.sv
module trap_vec_table #(
    parameter int          XLEN    = 32,
    parameter int          IDX_W   = 3,
    parameter logic [31:0] DEFAULT = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [XLEN-1:0]  rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [XLEN-1:0] entry [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry[e] <= XLEN'(DEFAULT);
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                entry[e] <= wr_data;
            end
        end
    end

    assign rd_data = entry[rd_idx];

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter #(
    parameter int XLEN   = 32,
    parameter int NSTAGE = 4,
    parameter int CODE_W = 2
) (
    input  logic [NSTAGE-1:0]        valid,
    input  logic [NSTAGE*CODE_W-1:0] codes,
    input  logic [NSTAGE*XLEN-1:0]   pcs,
    output logic                     any,
    output logic [CODE_W-1:0]        code,
    output logic [XLEN-1:0]          pc,
    output logic [NSTAGE-1:0]        kill
);
    // Youngest stage first, so that an older stage overrides it.
    always_comb begin
        any  = 1'b0;
        code = '0;
        pc   = '0;
        kill = '0;
        for (int k = 0; k < NSTAGE; k++) begin
            if (valid[k]) begin
                any  = 1'b1;
                code = codes[k*CODE_W +: CODE_W];
                pc   = pcs[k*XLEN +: XLEN];
                kill = NSTAGE'((64'd1 << (k + 1)) - 64'd1);
            end
        end
    end

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int          XLEN        = 32,
    parameter int          NSTAGE      = 4,
    parameter int          CODE_W      = 2,
    parameter logic [31:0] DEFAULT_VEC = 32'h0000_0100,
    localparam int         IDX_W       = CODE_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NSTAGE-1:0]        exc_valid_i,
    input  logic [NSTAGE*CODE_W-1:0] exc_cause_i,
    input  logic [NSTAGE*XLEN-1:0]   stage_pc_i,
    input  logic                     irq_i,
    input  logic [CODE_W-1:0]        irq_src_i,
    input  logic                     mret_i,
    input  logic                     cfg_we_i,
    input  logic [IDX_W-1:0]         cfg_idx_i,
    input  logic [XLEN-1:0]          cfg_data_i,
    output logic [NSTAGE-1:0]        flush_o,
    output logic                     redirect_o,
    output logic [XLEN-1:0]          redirect_pc_o,
    output logic [XLEN-1:0]          epc_o,
    output logic [IDX_W-1:0]         cause_o
);
    localparam logic [NSTAGE-1:0] FLUSH_ALL = '1;
    localparam int                MEM_LO    = (NSTAGE - 1) * XLEN;

    trap_state_e       state_q, state_d;
    logic [XLEN-1:0]   epc_q;
    logic [IDX_W-1:0]  cause_q;
    logic [IDX_W-1:0]  held_idx_q;
    logic [XLEN-1:0]   held_pc_q;

    logic              arb_any;
    logic [CODE_W-1:0] arb_code;
    logic [XLEN-1:0]   arb_pc;
    logic [NSTAGE-1:0] arb_kill;

    logic              take;
    logic              ret;
    logic              park;
    logic [IDX_W-1:0]  take_idx;
    logic [XLEN-1:0]   take_epc;
    logic [NSTAGE-1:0] flush_d;
    logic [XLEN-1:0]   vec_addr;
    logic [IDX_W-1:0]  irq_idx;
    logic [XLEN-1:0]   mem_pc;

    assign irq_idx = {1'b1, irq_src_i};
    assign mem_pc  = stage_pc_i[MEM_LO +: XLEN];

    trap_arbiter #(
        .XLEN  (XLEN),
        .NSTAGE(NSTAGE),
        .CODE_W(CODE_W)
    ) u_arb (
        .valid(exc_valid_i),
        .codes(exc_cause_i),
        .pcs  (stage_pc_i),
        .any  (arb_any),
        .code (arb_code),
        .pc   (arb_pc),
        .kill (arb_kill)
    );

    trap_vec_table #(
        .XLEN   (XLEN),
        .IDX_W  (IDX_W),
        .DEFAULT(DEFAULT_VEC)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we_i),
        .wr_idx (cfg_idx_i),
        .wr_data(cfg_data_i),
        .rd_idx (take_idx),
        .rd_data(vec_addr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and trap decision
    always_comb begin
        state_d  = state_q;
        take     = 1'b0;
        ret      = 1'b0;
        park     = 1'b0;
        take_idx = '0;
        take_epc = epc_q;
        flush_d  = '0;
        unique case (state_q)
            ST_RUN: begin
                if (mret_i) begin
                    ret     = 1'b1;
                    flush_d = FLUSH_ALL;
                end else if (arb_any) begin
                    take     = 1'b1;
                    take_idx = {1'b0, arb_code};
                    take_epc = arb_pc;
                    flush_d  = arb_kill;
                    state_d  = ST_HANDLER;
                end else if (irq_i) begin
                    take     = 1'b1;
                    take_idx = irq_idx;
                    take_epc = mem_pc;
                    flush_d  = FLUSH_ALL;
                    state_d  = ST_HANDLER;
                end
            end
            ST_HANDLER: begin
                if (mret_i) begin
                    flush_d = FLUSH_ALL;
                    if (irq_i) begin
                        take     = 1'b1;
                        take_idx = irq_idx;
                        take_epc = epc_q;
                    end else begin
                        ret     = 1'b1;
                        state_d = ST_RUN;
                    end
                end else if (arb_any || irq_i) begin
                    park    = 1'b1;
                    state_d = ST_HELD;
                end
            end
            ST_HELD: begin
                if (mret_i) begin
                    take     = 1'b1;
                    take_idx = held_idx_q;
                    take_epc = held_idx_q[IDX_W-1] ? epc_q : held_pc_q;
                    flush_d  = FLUSH_ALL;
                    state_d  = ST_HANDLER;
                end
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // Output and record registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc_q      <= '0;
            cause_q    <= '0;
            held_idx_q <= '0;
            held_pc_q  <= '0;
        end else begin
            if (take) begin
                epc_q   <= take_epc;
                cause_q <= take_idx;
            end
            if (park) begin
                held_idx_q <= arb_any ? {1'b0, arb_code} : irq_idx;
                held_pc_q  <= arb_pc;
            end
        end
    end

    assign flush_o       = flush_d;
    assign redirect_o    = take | ret;
    assign redirect_pc_o = take ? vec_addr : (ret ? epc_q : '0);
    assign epc_o         = epc_q;
    assign cause_o       = cause_q;

endmodule

// File: rtl/trap_ctrl_sva.sv
module trap_ctrl_sva
    import trap_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int NSTAGE = 4,
    parameter int CODE_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NSTAGE-1:0]   exc_valid_i,
    input logic                irq_i,
    input logic [CODE_W-1:0]   irq_src_i,
    input logic                mret_i,
    input logic [XLEN-1:0]     mem_pc,
    input logic [NSTAGE-1:0]   flush_o,
    input logic                redirect_o,
    input logic [XLEN-1:0]     redirect_pc_o,
    input logic [XLEN-1:0]     epc_o,
    input logic [CODE_W:0]     cause_o,
    input trap_state_e         state
);
    // R2: a flush comes only with a redirect, and always includes fetch
    a_r2_flush_needs_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> (flush_o == '0));
    a_r2_redirect_kills_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_o |-> flush_o[0]);

    // R4: the saved PC moves only when a redirect happens
    a_r4_epc_only_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |=> $stable(epc_o) && $stable(cause_o));

    // R5: interrupt in RUN records source and memory-stage PC
    a_r5_irq_record: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !mret_i && exc_valid_i == '0 && irq_i)
        |=> (cause_o == {1'b1, $past(irq_src_i)}) && (epc_o == $past(mem_pc)));

    // R6: fault beats interrupt
    a_r6_fault_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !mret_i && exc_valid_i != '0 && irq_i) |=> !cause_o[CODE_W]);

    // R7: masked states never redirect without a return
    a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN && !mret_i) |-> !redirect_o && flush_o == '0);

    // R8: plain return goes back to the saved PC
    a_r8_return_target: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HANDLER && mret_i && !irq_i)
        |-> redirect_o && redirect_pc_o == epc_o && flush_o == '1);

    // R11: return in RUN outranks faults
    a_r11_return_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && mret_i) |-> redirect_pc_o == epc_o && flush_o == '1);

endmodule

bind trap_ctrl trap_ctrl_sva #(
    .XLEN  (XLEN),
    .NSTAGE(NSTAGE),
    .CODE_W(CODE_W)
) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_valid_i  (exc_valid_i),
    .irq_i        (irq_i),
    .irq_src_i    (irq_src_i),
    .mret_i       (mret_i),
    .mem_pc       (stage_pc_i[(NSTAGE-1)*XLEN +: XLEN]),
    .flush_o      (flush_o),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o),
    .epc_o        (epc_o),
    .cause_o      (cause_o),
    .state        (state_q)
);

// File: tb/trap_ctrl_tb.sv
module trap_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VBASE = 32'h8000_0000;

    // {valid[4], causes[8], irq, src[2], flush[4], cause[3], stage[2]}
    localparam logic [23:0] TBL [0:9] = '{
        {4'b0001, 8'b0000_0000, 1'b0, 2'd0, 4'b0001, 3'd0, 2'd0},
        {4'b0010, 8'b0000_0100, 1'b0, 2'd0, 4'b0011, 3'd1, 2'd1},
        {4'b0100, 8'b0010_0000, 1'b0, 2'd0, 4'b0111, 3'd2, 2'd2},
        {4'b1000, 8'b1100_0000, 1'b0, 2'd0, 4'b1111, 3'd3, 2'd3},
        {4'b0111, 8'b0010_0100, 1'b0, 2'd0, 4'b0111, 3'd2, 2'd2},
        {4'b1011, 8'b1100_0100, 1'b0, 2'd0, 4'b1111, 3'd3, 2'd3},
        {4'b0000, 8'b0000_0000, 1'b1, 2'd2, 4'b1111, 3'd6, 2'd3},
        {4'b0010, 8'b0000_0100, 1'b1, 2'd3, 4'b0011, 3'd1, 2'd1},
        {4'b0110, 8'b0000_0100, 1'b0, 2'd0, 4'b0111, 3'd0, 2'd2},
        {4'b0000, 8'b0000_0000, 1'b1, 2'd0, 4'b1111, 3'd4, 2'd3}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   exc_valid = '0;
    logic [7:0]   exc_cause = '0;
    logic [127:0] stage_pc;
    logic         irq = 1'b0;
    logic [1:0]   irq_src = '0;
    logic         mret = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_idx = '0;
    logic [31:0]  cfg_data = '0;
    logic [3:0]   flush;
    logic         redirect;
    logic [31:0]  redirect_pc;
    logic [31:0]  epc;
    logic [2:0]   cause;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign stage_pc = {32'h1000_0004, 32'h1000_0008, 32'h1000_000C, 32'h1000_0010};

    always #(CLK_PERIOD/2) clk = ~clk;

    trap_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .exc_valid_i(exc_valid), .exc_cause_i(exc_cause), .stage_pc_i(stage_pc),
        .irq_i(irq), .irq_src_i(irq_src), .mret_i(mret),
        .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_data_i(cfg_data),
        .flush_o(flush), .redirect_o(redirect), .redirect_pc_o(redirect_pc),
        .epc_o(epc), .cause_o(cause)
    );

    function automatic logic [31:0] pc_of(input logic [1:0] s);
        return stage_pc[s*32 +: 32];
    endfunction

    function automatic logic [31:0] vec_of(input logic [2:0] c);
        return VBASE + 32'(c) * 32'h40;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        exc_valid = '0; exc_cause = '0; irq = 1'b0; irq_src = '0; mret = 1'b0;
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) nxt();
        // R1: reset state
        chk("R1 flush", 32'(flush), 32'h0);
        chk("R1 redirect", 32'(redirect), 32'h0);
        chk("R1 epc", epc, 32'h0);
        chk("R1 cause", 32'(cause), 32'h0);
        rst_n = 1'b1;
        nxt();

        // R10: default vector entry used before any write
        exc_valid = 4'b0100; exc_cause = 8'b0010_0000;
        #1 chk("R10 default vector", redirect_pc, 32'h0000_0100);
        nxt(); idle(); mret = 1'b1;
        nxt(); idle();

        // R10: program the table
        for (int i = 0; i < 8; i++) begin
            cfg_we = 1'b1; cfg_idx = 3'(i); cfg_data = vec_of(3'(i));
            nxt();
        end
        cfg_we = 1'b0;

        // Table walk: R2, R3, R4, R5, R6, R8
        for (int i = 0; i < 10; i++) begin
            logic [23:0] t;
            t = TBL[i];
            exc_valid = t[23:20]; exc_cause = t[19:12]; irq = t[11]; irq_src = t[10:9];
            #1;
            chk($sformatf("R2/R3 flush v%0d", i), 32'(flush), 32'(t[8:5]));
            chk($sformatf("R2 redirect v%0d", i), 32'(redirect), 32'h1);
            chk($sformatf("R3/R6/R10 target v%0d", i), redirect_pc, vec_of(t[4:2]));
            nxt(); idle();
            chk($sformatf("R4/R5 epc v%0d", i), epc, pc_of(t[1:0]));
            chk($sformatf("R4/R5 cause v%0d", i), 32'(cause), 32'(t[4:2]));
            mret = 1'b1;
            #1;
            chk($sformatf("R8 return pc v%0d", i), redirect_pc, pc_of(t[1:0]));
            chk($sformatf("R8 return flush v%0d", i), 32'(flush), 32'hF);
            nxt(); idle();
        end

        // R7 + R9: masked fault is parked, later arrivals dropped
        exc_valid = 4'b1000; exc_cause = 8'b1100_0000;
        nxt(); idle();
        exc_valid = 4'b0010; exc_cause = 8'b0000_0100; irq = 1'b1; irq_src = 2'd2;
        #1;
        chk("R7 masked redirect", 32'(redirect), 32'h0);
        chk("R7 masked flush", 32'(flush), 32'h0);
        nxt(); idle();
        chk("R7 masked epc", epc, pc_of(2'd3));
        chk("R7 masked cause", 32'(cause), 32'd3);
        irq = 1'b1; irq_src = 2'd1;
        nxt(); idle();
        mret = 1'b1;
        #1;
        chk("R9 chained target", redirect_pc, vec_of(3'd1));
        chk("R9 chained flush", 32'(flush), 32'hF);
        nxt(); idle();
        chk("R9 chained epc", epc, pc_of(2'd1));
        chk("R9 chained cause", 32'(cause), 32'd1);
        mret = 1'b1;
        #1 chk("R8 return after chain", redirect_pc, pc_of(2'd1));
        nxt(); idle();

        // R8: unmasked after return, interrupt taken
        irq = 1'b1; irq_src = 2'd3;
        #1 chk("R8 unmasked irq", redirect_pc, vec_of(3'd7));
        nxt(); idle();
        // R9: parked interrupt keeps return address
        irq = 1'b1; irq_src = 2'd1;
        nxt(); idle();
        mret = 1'b1;
        #1 chk("R9 parked irq target", redirect_pc, vec_of(3'd5));
        nxt(); idle();
        chk("R9 parked irq epc", epc, pc_of(2'd3));
        chk("R9 parked irq cause", 32'(cause), 32'd5);

        // R9: interrupt coinciding with mret in HANDLER chains
        mret = 1'b1; irq = 1'b1; irq_src = 2'd2;
        #1 chk("R9 coincident irq target", redirect_pc, vec_of(3'd6));
        nxt(); idle();
        chk("R9 coincident irq cause", 32'(cause), 32'd6);
        mret = 1'b1;
        nxt(); idle();

        // R11: mret in RUN outranks a memory fault
        mret = 1'b1; exc_valid = 4'b1000; exc_cause = 8'b0100_0000;
        #1;
        chk("R11 return target", redirect_pc, pc_of(2'd3));
        chk("R11 flush", 32'(flush), 32'hF);
        nxt(); idle();
        chk("R11 cause kept", 32'(cause), 32'd6);
        exc_valid = 4'b0001; exc_cause = 8'b0000_0011;
        #1 chk("R11 still RUN", redirect_pc, vec_of(3'd3));
        nxt(); idle();

        // R10: rewrite one entry and use it the next cycle
        mret = 1'b1;
        nxt(); idle();
        cfg_we = 1'b1; cfg_idx = 3'd2; cfg_data = 32'hCAFE_0000;
        nxt(); cfg_we = 1'b0;
        exc_valid = 4'b0100; exc_cause = 8'b0010_0000;
        #1 chk("R10 rewritten entry", redirect_pc, 32'hCAFE_0000);
        nxt(); idle();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule